// File: doc/BRIEF.md
# Register File with Same-Cycle Write Bypass

This block is the architectural register storage for a small pipelined processor. It offers one write port, driven by the write-back stage, and two independent read ports, driven by the decode stage. Writes are committed on the rising clock edge. Reads are combinational from the address inputs.

When the write-back stage writes a register in the same cycle that the decode stage reads that register, the stored contents are still the old value. Each read port therefore carries its own forwarding multiplexer. The multiplexer compares the read address with the active write address and passes the incoming write data straight to the output, so a producer two instructions ahead is seen without a stall.

Register zero is hard-wired: it always reads as zero. Writes to it are dropped, and they are never forwarded. An asynchronous active-low reset, released synchronously to the clock, clears every register.

Top module: `rfb_regfile`

## Requirements
- R1: While `rst_n` is low, and after it is released with no write since, every address reads zero on both ports.
- R2: With `wr_en` high and `wr_addr` non-zero, `wr_data` is stored at the rising edge. A later read of that address, with no newer write to it, returns that value.
- R3: With `wr_en` low, no stored register changes at the clock edge, whatever `wr_addr` and `wr_data` carry.
- R4: Address 0 reads zero on both ports at all times. A write to address 0 changes nothing, and it is not forwarded to a port reading address 0 in the same cycle.
- R5: When `wr_en` is high, `wr_addr` is non-zero and `rd_addr_a` equals `wr_addr`, `rd_data_a` equals `wr_data` in that same cycle.
- R6: When `wr_en` is high, `wr_addr` is non-zero and `rd_addr_b` equals `wr_addr`, `rd_data_b` equals `wr_data` in that same cycle.
- R7: Forwarding is decided per port. A port whose address does not match the write address returns stored contents, even while the other port is forwarding. Both ports forward when both match.
- R8: Read data follows a change of read address within the same cycle, with no clock edge in between.
- R9: With `wr_en` low, a read whose address equals `wr_addr` returns the stored value, not `wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write enable from write-back |
| wr_addr | input | ADDR_W (3) | Register written |
| wr_data | input | DATA_W (32) | Value written |
| rd_addr_a | input | ADDR_W (3) | Read address, port A |
| rd_addr_b | input | ADDR_W (3) | Read address, port B |
| rd_data_a | output | DATA_W (32) | Read data, port A |
| rd_data_b | output | DATA_W (32) | Read data, port B |

## Verification
The bench builds the block with its default parameters: eight registers of 32 bits each, with a 3-bit address. With only eight addresses, random stimulus makes the read addresses meet the write address in roughly one cycle in eight per port, and it lands on register zero about as often. As a result, forwarding on one port, on both ports, and the suppressed forward into register zero all occur many times, alongside directed sequences for reset, writes while disabled and address changes within a cycle. The 32-bit width lets random data tell a stale word from a forwarded one with near certainty.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

  // Source chosen by a read port's forwarding multiplexer
  typedef enum logic [0:0] {
    SRC_STORE = 1'b0,
    SRC_WRITE = 1'b1
  } rd_src_e;

  localparam int unsigned RD_PORTS = 2;

endpackage

// File: rtl/rfb_wr_decode.sv
module rfb_wr_decode #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  output logic [NUM_REGS-1:0] row_we
);

  // Row 0 is hard-wired and never takes a write
  assign row_we[0] = 1'b0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_row
    assign row_we[g] = wr_en && (wr_addr == ADDR_W'(g));
  end

endmodule

// File: rtl/rfb_store.sv
module rfb_store #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:0]              row_we,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  rows
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_row
    if (g == 0) begin : g_zero
      assign rows[g] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] row_d;
      logic [DATA_W-1:0] row_q;

      always_comb begin
        row_d = row_q;
        if (row_we[g]) row_d = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          row_q <= '0;
        end else if (row_we[g]) begin
          row_q <= row_d;
        end
      end

      assign rows[g] = row_q;
    end
  end

endmodule

// File: rtl/rfb_read_port.sv
module rfb_read_port
  import rfb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] rows,
  input  logic [ADDR_W-1:0]               rd_addr,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [DATA_W-1:0]               rd_data
);

  rd_src_e           src;
  logic [DATA_W-1:0] stored;

  // Forward only a live write to a real register at this address
  always_comb begin
    src = SRC_STORE;
    if (wr_en && (wr_addr == rd_addr) && (rd_addr != '0)) src = SRC_WRITE;
  end

  always_comb begin
    stored = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == ADDR_W'(i)) stored = rows[i];
    end
  end

  always_comb begin
    unique case (src)
      SRC_WRITE: rd_data = wr_data;
      default:   rd_data = stored;
    endcase
  end

endmodule

// File: rtl/rfb_regfile.sv
module rfb_regfile
  import rfb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);

  logic [NUM_REGS-1:0]             row_we;
  logic [NUM_REGS-1:0][DATA_W-1:0] rows;
  logic [RD_PORTS-1:0][ADDR_W-1:0] port_addr;
  logic [RD_PORTS-1:0][DATA_W-1:0] port_data;

  rfb_wr_decode #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .row_we  (row_we)
  );

  rfb_store #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .row_we  (row_we),
    .wr_data (wr_data),
    .rows    (rows)
  );

  assign port_addr[0] = rd_addr_a;
  assign port_addr[1] = rd_addr_b;

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
    rfb_read_port #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W)
    ) u_rd (
      .rows    (rows),
      .rd_addr (port_addr[p]),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_data (port_data[p])
    );
  end

  assign rd_data_a = port_data[0];
  assign rd_data_b = port_data[1];

endmodule

// File: rtl/rfb_regfile_chk.sv
module rfb_regfile_chk #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [DATA_W-1:0] rd_data_b
);

  // R4
  zero_reg_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |-> (rd_data_a == '0));

  // R4
  zero_reg_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_b == '0) |-> (rd_data_b == '0));

  // R5
  bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr != '0) && (rd_addr_a == wr_addr)) |-> (rd_data_a == wr_data));

  // R6
  bypass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr != '0) && (rd_addr_b == wr_addr)) |-> (rd_data_b == wr_data));

  // R2
  write_commit_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr != '0)) ##1
    ((rd_addr_a == $past(wr_addr)) && !(wr_en && (wr_addr == rd_addr_a)))
    |-> (rd_data_a == $past(wr_data)));

  // R3
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(rd_addr_a) && !(wr_en && (wr_addr == rd_addr_a)))
    |-> $stable(rd_data_a));

endmodule

bind rfb_regfile rfb_regfile_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (.*);

// File: tb/rfb_regfile_tb.sv
module rfb_regfile_tb;

  localparam int NREG = 8;
  localparam int DW   = 32;
  localparam int AW   = 3;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] rd_addr_a;
  logic [AW-1:0] rd_addr_b;
  logic [DW-1:0] rd_data_a;
  logic [DW-1:0] rd_data_b;

  int checks;
  int failures;
  int cycles;
  bit done;
  logic [DW-1:0] model [NREG];

  rfb_regfile u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [DW-1:0] expect_rd(logic [AW-1:0] a);
    if (a == '0) return '0;
    if (wr_en && wr_addr == a) return wr_data;
    return model[a];
  endfunction

  function automatic string tag_for(logic [AW-1:0] a, string hit_tag);
    if (a == '0) return "R4";
    if (wr_addr == a && wr_en) return hit_tag;
    if (wr_addr == a && !wr_en) return "R9";
    return "R2";
  endfunction

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag_ovr);
    check(tag_ovr != "" ? tag_ovr : tag_for(rd_addr_a, "R5"), "port A",
          rd_data_a, expect_rd(rd_addr_a));
    check(tag_ovr != "" ? tag_ovr : tag_for(rd_addr_b, "R6"), "port B",
          rd_data_b, expect_rd(rd_addr_b));
  endtask

  task automatic step(logic we, logic [AW-1:0] wa, logic [DW-1:0] wd,
                      logic [AW-1:0] ra, logic [AW-1:0] rb, string tag_ovr);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
    #1;
    compare(tag_ovr);
    @(posedge clk);
    if (we && wa != '0) model[wa] = wd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    #1;
    for (int i = 0; i < NREG; i++) begin
      rd_addr_a = AW'(i); rd_addr_b = AW'(NREG - 1 - i);
      #1;
      check("R1", "in reset A", rd_data_a, '0);
      check("R1", "in reset B", rd_data_b, '0);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    checks = 0; failures = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr_a = '0; rd_addr_b = '0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (2) @(posedge clk);
    do_reset();

    // R1: all zero after release
    for (int i = 0; i < NREG; i++)
      step(1'b0, '0, 32'hFFFF_FFFF, AW'(i), AW'(i), "R1");

    // R2: fill registers, then read back
    for (int i = 1; i < NREG; i++)
      step(1'b1, AW'(i), 32'h1000_0000 + 32'(i * 17), AW'(i - 1), '0, "");
    for (int i = 0; i < NREG; i++)
      step(1'b0, '0, '0, AW'(i), AW'(NREG - 1 - i), "R2");

    // R3: disabled writes change nothing
    for (int i = 0; i < NREG; i++)
      step(1'b0, AW'(i), 32'hDEAD_0000 + 32'(i), 3'd7, 3'd6, "");
    for (int i = 0; i < NREG; i++)
      step(1'b0, '0, '0, AW'(i), AW'(i), "R3");

    // R4: write to register 0, read it same cycle and after
    step(1'b1, '0, 32'hCAFE_F00D, '0, '0, "R4");
    step(1'b0, '0, '0, '0, '0, "R4");

    // R5 / R6: collisions on each port
    step(1'b1, 3'd3, 32'hA5A5_0003, 3'd3, 3'd1, "R5");
    step(1'b1, 3'd4, 32'h5A5A_0004, 3'd2, 3'd4, "R6");

    // R7: both ports forward; one forwards while the other reads stored
    step(1'b1, 3'd5, 32'h7777_0005, 3'd5, 3'd5, "R7");
    step(1'b1, 3'd6, 32'h6666_0006, 3'd6, 3'd5, "R7");
    step(1'b1, 3'd2, 32'h2222_0002, 3'd3, 3'd2, "R7");

    // R9: matching address with write disabled
    step(1'b0, 3'd6, 32'h0BAD_0BAD, 3'd6, 3'd6, "R9");

    // R8: address change within one cycle
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      rd_addr_a = AW'(i); rd_addr_b = AW'((i + 3) % NREG);
      #1;
      check("R8", "port A mid-cycle", rd_data_a, expect_rd(rd_addr_a));
      check("R8", "port B mid-cycle", rd_data_b, expect_rd(rd_addr_b));
    end

    // Random traffic against the reference model
    for (int n = 0; n < 2000; n++)
      step(1'($urandom_range(0, 3) != 0), AW'($urandom_range(0, NREG - 1)),
           DW'($urandom), AW'($urandom_range(0, NREG - 1)),
           AW'($urandom_range(0, NREG - 1)), "");

    // R1: reset in mid-run clears contents
    do_reset();
    for (int i = 0; i < NREG; i++)
      step(1'b0, '0, '0, AW'(i), AW'(i), "R1");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule